// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Set/Reset

This block controls one 16-pin general purpose I/O port through a plain 32-bit register bus made of a byte address, a write strobe, write data and combinational read data. Software uses it to choose each pin's role (digital input, general output, alternate function or analog) and to store the pin's drive type, slew speed code, pull selection and the 4-bit number of its alternate function. The block then produces the pad controls for each pin: output value, output enable, pull-up enable, pull-down enable and speed code.

Output levels are held in an output data register. That register can be written directly, or changed through a write-only set/clear register. A single write to the set/clear register can raise some bits and lower others and leave the rest as they are. Pin levels pass through a two-flop synchronizer before software reads them. Each pin has its own 16-way multiplexer over peripheral signals for the alternate-function role, and open-drain gating applies to both driven roles.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, and pin_oe, pin_pu, pin_pd and pin_speed are all zero.
- R2: The byte offsets 0x00 (mode, 2 bits per pin, pin n at bits 2n+1:2n), 0x04 (drive type, bits 15:0 stored, bits 31:16 read zero), 0x08 (speed, 2 bits per pin), 0x0C (pull, 2 bits per pin), 0x20 (function select for pins 0-7) and 0x24 (function select for pins 8-15) read back what was written. The speed field of pin n appears on pin_speed[2n+1:2n].
- R3: A write to offset 0x14 stores bits 15:0 as the output data, and bits 31:16 of the output data read back as zero.
- R4: A write to offset 0x18 sets output bit k where write bit k is 1 and clears output bit k where write bit k+16 is 1. Output bits whose mask bits are both 0 keep their value.
- R5: When one write to 0x18 has both bit k and bit k+16 at 1, output bit k becomes 1.
- R6: Offset 0x18 always reads zero.
- R7: Offset 0x10 returns the pin_in levels in bits 15:0 after two clock edges of synchronization. Bits 31:16 read zero.
- R8: A pin in mode 11 (analog) reads 0 at offset 0x10 and has pin_oe low.
- R9: A pin in mode 01 (general output) with drive type 0 (push-pull) drives its output data bit on pin_out with pin_oe high.
- R10: A pin in mode 10 (alternate function) drives af_in[16*n+f] on pin_out, where f is its 4-bit field at bits 4(n mod 8)+3:4(n mod 8) of offset 0x20 (pins 0-7) or 0x24 (pins 8-15).
- R11: With drive type 1 (open-drain), a pin in mode 01 or 10 has pin_oe high only while its output value is 0.
- R12: Pull code 01 raises pin_pu, code 10 raises pin_pd, and codes 00 and 11 raise neither.
- R13: A pin in mode 00 (input) has pin_oe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Asynchronous pad input levels |
| af_in | input | 256 | Peripheral signals, 16 per pin, pin n function f at bit 16n+f |
| pin_out | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_pu | output | 16 | Pull-up enable per pin |
| pin_pd | output | 16 | Pull-down enable per pin |
| pin_speed | output | 32 | Speed code per pin, 2 bits each |

## Verification
The set request and the clear request for the same output bit can arrive in one write, and the bench provokes this with many set/clear word pairs whose masks overlap. Each result is judged against a model in the bench in which set overrides clear. A second overlap occurs between a pin's open-drain gating and its output value within one cycle. The bench sweeps all 16 function selects, each with its own peripheral pattern, in both drive types, and requires pin_oe to be the complement of the expected value wherever drive type 1 applies.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS  = 16;
    localparam int NAF    = 16;
    localparam int AFW    = $clog2(NAF);
    localparam int ADDR_W = 6;
    localparam int DW     = 32;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_OTYPE = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_SPEED = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_PULL  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_IDR   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_ODR   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_SETCL = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_AFLO  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_AFHI  = 6'h24;

    typedef enum logic [1:0] {
        MODE_IN  = 2'b00,
        MODE_OUT = 2'b01,
        MODE_ALT = 2'b10,
        MODE_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_UP   = 2'b01,
        PULL_DN   = 2'b10,
        PULL_RSV  = 2'b11
    } pull_e;

    typedef struct packed {
        pin_mode_e        mode;
        logic             od;
        pull_e            pull;
        logic [AFW-1:0]   afsel;
    } pin_cfg_t;

    function automatic logic mode_drives(pin_mode_e m);
        return (m == MODE_OUT) || (m == MODE_ALT);
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic [DW-1:0]         wdata,
    input  logic [NPINS-1:0]      idr_in,
    output logic [DW-1:0]         rdata,
    output logic [2*NPINS-1:0]    mode_q,
    output logic [NPINS-1:0]      otype_q,
    output logic [2*NPINS-1:0]    speed_q,
    output logic [2*NPINS-1:0]    pull_q,
    output logic [AFW*NPINS-1:0]  af_q,
    output logic [NPINS-1:0]      odr_q
);

    localparam int HALF = AFW * NPINS / 2;

    logic [NPINS-1:0] set_mask;
    logic [NPINS-1:0] clr_mask;

    assign set_mask = wdata[NPINS-1:0];
    assign clr_mask = wdata[2*NPINS-1:NPINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            otype_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            af_q    <= '0;
            odr_q   <= '0;
        end else if (we) begin
            case (addr)
                OFS_MODE:  mode_q  <= wdata[2*NPINS-1:0];
                OFS_OTYPE: otype_q <= wdata[NPINS-1:0];
                OFS_SPEED: speed_q <= wdata[2*NPINS-1:0];
                OFS_PULL:  pull_q  <= wdata[2*NPINS-1:0];
                OFS_ODR:   odr_q   <= wdata[NPINS-1:0];
                OFS_SETCL: odr_q   <= (odr_q & ~clr_mask) | set_mask;
                OFS_AFLO:  af_q[HALF-1:0]      <= wdata[HALF-1:0];
                OFS_AFHI:  af_q[2*HALF-1:HALF] <= wdata[HALF-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE:  rdata[2*NPINS-1:0] = mode_q;
            OFS_OTYPE: rdata[NPINS-1:0]   = otype_q;
            OFS_SPEED: rdata[2*NPINS-1:0] = speed_q;
            OFS_PULL:  rdata[2*NPINS-1:0] = pull_q;
            OFS_IDR:   rdata[NPINS-1:0]   = idr_in;
            OFS_ODR:   rdata[NPINS-1:0]   = odr_q;
            OFS_AFLO:  rdata[HALF-1:0]    = af_q[HALF-1:0];
            OFS_AFHI:  rdata[HALF-1:0]    = af_q[2*HALF-1:HALF];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
(
    input  pin_cfg_t         cfg,
    input  logic             odr_bit,
    input  logic [NAF-1:0]   af_vec,
    output logic             out_val,
    output logic             out_en,
    output logic             pu_en,
    output logic             pd_en
);

    always_comb begin
        case (cfg.mode)
            MODE_OUT: out_val = odr_bit;
            MODE_ALT: out_val = af_vec[cfg.afsel];
            default:  out_val = 1'b0;
        endcase
        out_en = mode_drives(cfg.mode) && (!cfg.od || !out_val);
        pu_en  = (cfg.pull == PULL_UP);
        pd_en  = (cfg.pull == PULL_DN);
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    input  logic [NPINS*NAF-1:0]  af_in,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe,
    output logic [NPINS-1:0]      pin_pu,
    output logic [NPINS-1:0]      pin_pd,
    output logic [2*NPINS-1:0]    pin_speed
);

    logic [2*NPINS-1:0]   mode_q;
    logic [NPINS-1:0]     otype_q;
    logic [2*NPINS-1:0]   speed_q;
    logic [2*NPINS-1:0]   pull_q;
    logic [AFW*NPINS-1:0] af_q;
    logic [NPINS-1:0]     odr_q;
    logic [NPINS-1:0]     in_sync;
    logic [NPINS-1:0]     ana_mask;
    logic [NPINS-1:0]     idr_view;

    gpio_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .idr_in  (idr_view),
        .rdata   (bus_rdata),
        .mode_q  (mode_q),
        .otype_q (otype_q),
        .speed_q (speed_q),
        .pull_q  (pull_q),
        .af_q    (af_q),
        .odr_q   (odr_q)
    );

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg.mode  = pin_mode_e'(mode_q[2*p +: 2]);
        assign cfg.od    = otype_q[p];
        assign cfg.pull  = pull_e'(pull_q[2*p +: 2]);
        assign cfg.afsel = af_q[AFW*p +: AFW];
        assign ana_mask[p] = (cfg.mode == MODE_ANA);

        gpio_pin_ctrl u_pin (
            .cfg     (cfg),
            .odr_bit (odr_q[p]),
            .af_vec  (af_in[NAF*p +: NAF]),
            .out_val (pin_out[p]),
            .out_en  (pin_oe[p]),
            .pu_en   (pin_pu[p]),
            .pd_en   (pin_pd[p])
        );
    end

    assign idr_view  = in_sync & ~ana_mask;
    assign pin_speed = speed_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DW-1:0]        bus_wdata,
    input logic [DW-1:0]        bus_rdata,
    input logic [NPINS-1:0]     pin_out,
    input logic [NPINS-1:0]     pin_oe,
    input logic [NPINS-1:0]     pin_pu,
    input logic [NPINS-1:0]     pin_pd,
    input logic [NPINS-1:0]     odr_q,
    input logic [2*NPINS-1:0]   mode_q,
    input logic [NPINS-1:0]     otype_q
);

    logic [NPINS-1:0] chk_ana;
    logic             setcl_wr;

    always_comb begin
        for (int p = 0; p < NPINS; p++)
            chk_ana[p] = (mode_q[2*p +: 2] == 2'b11);
    end

    assign setcl_wr = bus_we && (bus_addr == OFS_SETCL);

    assert_setclr_R4: assert property (@(posedge clk) disable iff (rst)
        setcl_wr |=> odr_q == (($past(odr_q) & ~$past(bus_wdata[2*NPINS-1:NPINS]))
                               | $past(bus_wdata[NPINS-1:0])));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (setcl_wr && |(bus_wdata[NPINS-1:0] & bus_wdata[2*NPINS-1:NPINS]))
        |=> ((odr_q & $past(bus_wdata[NPINS-1:0] & bus_wdata[2*NPINS-1:NPINS]))
             == $past(bus_wdata[NPINS-1:0] & bus_wdata[2*NPINS-1:NPINS])));

    assert_setcl_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_SETCL) |-> (bus_rdata == '0));

    assert_idr_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_IDR) |-> (bus_rdata[DW-1:NPINS] == '0));

    assert_analog_no_oe_R8: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & chk_ana) == '0);

    assert_od_gate_R11: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & otype_q & pin_out) == '0);

    assert_pull_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_pd) == '0);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .pin_pd    (pin_pd),
    .odr_q     (odr_q),
    .mode_q    (mode_q),
    .otype_q   (otype_q)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [5:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  pin_in = '0;
    logic [255:0] af_in = '0;
    logic [15:0]  pin_out, pin_oe, pin_pu, pin_pd;
    logic [31:0]  pin_speed;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .af_in(af_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu(pin_pu), .pin_pd(pin_pd), .pin_speed(pin_speed)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", total, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [15:0] odr_m;
        logic [15:0] exp16;
        logic [31:0] pats [3];
        logic [5:0]  cfgs [6];

        seed = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(6'h00, 32'h0, "R1 mode");
        rd(6'h04, 32'h0, "R1 otype");
        rd(6'h08, 32'h0, "R1 speed");
        rd(6'h0C, 32'h0, "R1 pull");
        rd(6'h10, 32'h0, "R1 idr");
        rd(6'h14, 32'h0, "R1 odr");
        rd(6'h20, 32'h0, "R1 aflo");
        rd(6'h24, 32'h0, "R1 afhi");
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        check("R1 pulls", {pin_pu, pin_pd}, 32'h0);
        check("R1 speed pins", pin_speed, 32'h0);

        // R2: configuration readback
        pats[0] = 32'hA5A5_5A5A;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h1234_5678;
        cfgs[0] = 6'h00; cfgs[1] = 6'h04; cfgs[2] = 6'h08;
        cfgs[3] = 6'h0C; cfgs[4] = 6'h20; cfgs[5] = 6'h24;
        for (int i = 0; i < 3; i++) begin
            for (int r = 0; r < 6; r++) begin
                wr(cfgs[r], pats[i]);
                rd(cfgs[r], (cfgs[r] == 6'h04) ? {16'h0, pats[i][15:0]} : pats[i], "R2 readback");
                if (cfgs[r] == 6'h08)
                    check("R2 pin_speed", pin_speed, pats[i]);
            end
        end
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h0);
        wr(6'h0C, 32'h0);

        // R3: direct output data write
        wr(6'h14, 32'hFFFF_1234);
        rd(6'h14, 32'h0000_1234, "R3 odr");
        odr_m = 16'h1234;

        // R4, R5, R6: set/clear sweep with overlapping masks
        for (int i = 0; i < 40; i++) begin
            seed = lcg(seed);
            wr(6'h18, seed);
            odr_m = (odr_m & ~seed[31:16]) | seed[15:0];
            rd(6'h14, {16'h0, odr_m}, "R4 R5 setclr");
            rd(6'h18, 32'h0, "R6 setclr reads zero");
        end
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h14, 32'h0000_FFFF, "R5 all overlap");
        wr(6'h18, 32'h00F0_0000);
        rd(6'h14, 32'h0000_FF0F, "R4 clear only");
        wr(6'h18, 32'h0000_0000);
        rd(6'h14, 32'h0000_FF0F, "R4 zero masks");
        odr_m = 16'hFF0F;

        // R13: input mode, no drive
        #1;
        check("R13 input oe", {16'h0, pin_oe}, 32'h0);

        // R9: general output, push-pull
        wr(6'h00, 32'h5555_5555);
        #1;
        check("R9 out value", {16'h0, pin_out}, {16'h0, odr_m});
        check("R9 out enable", {16'h0, pin_oe}, 32'h0000_FFFF);
        wr(6'h14, 32'h0000_3C96);
        #1;
        check("R9 out value 2", {16'h0, pin_out}, 32'h0000_3C96);

        // R11: open-drain in output mode
        wr(6'h04, 32'h0000_FFFF);
        #1;
        check("R11 od output", {16'h0, pin_oe}, {16'h0, ~16'h3C96});

        // R10: alternate function sweep, uniform select
        wr(6'h04, 32'h0);
        wr(6'h00, 32'hAAAA_AAAA);
        for (int f = 0; f < 16; f++) begin
            wr(6'h20, {8{f[3:0]}});
            wr(6'h24, {8{f[3:0]}});
            @(negedge clk);
            for (int w = 0; w < 8; w++) begin
                seed = lcg(seed);
                af_in[32*w +: 32] = seed;
            end
            #1;
            for (int p = 0; p < 16; p++) exp16[p] = af_in[16*p + f];
            check("R10 af uniform", {16'h0, pin_out}, {16'h0, exp16});
            check("R10 af oe", {16'h0, pin_oe}, 32'h0000_FFFF);
        end

        // R10, R11: per-pin select equal to pin index, both drive types
        wr(6'h20, 32'h7654_3210);
        wr(6'h24, 32'hFEDC_BA98);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            for (int w = 0; w < 8; w++) begin
                seed = lcg(seed);
                af_in[32*w +: 32] = seed;
            end
            #1;
            for (int p = 0; p < 16; p++) exp16[p] = af_in[16*p + p];
            check("R10 af per pin", {16'h0, pin_out}, {16'h0, exp16});
            wr(6'h04, 32'h0000_FFFF);
            #1;
            check("R11 od af", {16'h0, pin_oe}, {16'h0, ~exp16});
            wr(6'h04, 32'h0);
        end

        // R12: pull code sweep
        for (int c = 0; c < 4; c++) begin
            wr(6'h0C, {16{c[1:0]}});
            #1;
            check("R12 pull up", {16'h0, pin_pu}, (c == 1) ? 32'h0000_FFFF : 32'h0);
            check("R12 pull down", {16'h0, pin_pd}, (c == 2) ? 32'h0000_FFFF : 32'h0);
        end

        // R7: two-edge synchronizer latency
        wr(6'h00, 32'h0);
        bus_addr = 6'h10;
        pin_in = 16'h0;
        repeat (3) @(negedge clk);
        pin_in = 16'hC3A5;
        @(negedge clk);
        rd(6'h10, 32'h0, "R7 after one edge");
        @(negedge clk);
        rd(6'h10, 32'h0000_C3A5, "R7 after two edges");
        pin_in = 16'h5A0F;
        repeat (2) @(negedge clk);
        rd(6'h10, 32'h0000_5A0F, "R7 second value");

        // R8: analog on even pins, output on odd pins
        pin_in = 16'hFFFF;
        wr(6'h14, 32'h0000_FFFF);
        wr(6'h00, 32'h7777_7777);
        repeat (2) @(negedge clk);
        rd(6'h10, 32'h0000_AAAA, "R8 analog idr");
        check("R8 analog oe", {16'h0, pin_oe}, 32'h0000_AAAA);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule